// File: doc/BRIEF.md
# Tape Controller Register Interface

This block is the bus-facing register file and command logic of a magnetic tape controller that serves up to eight drives. A host reads and writes six 16-bit registers with word or byte accesses: status, command, byte count, current address, an 8-bit data buffer and a free-running read-lines register. The block keeps the done, error and interrupt-enable state, drives a level interrupt request, and rejects commands that cannot run on the selected drive.

An accepted command produces a one-cycle go pulse to a separate transfer engine, together with the function code, unit number, byte count, 18-bit memory address, density and parity selection. When the engine finishes, it hands back a completion record: error flags, the final byte count and the final address. The completion channel is valid/ready. `cmpl_ready` is high only while an operation is outstanding, that is while done is clear. A record offered while `cmpl_ready` is low is not taken and has no effect. The engine holds `cmpl_valid` and its data until a cycle in which both are high. Per-drive condition lines (online, beginning of tape, write-locked, rewinding, busy) come from outside the block.

Top module: `tape_ctl_regs`

## Requirements
- R1: The register index is `bus_addr[3:1]`: 0 status (read-only, writes ignored), 1 command, 2 byte count, 3 current address, 4 data buffer, 5 read lines (read-only). Indexes 6 and 7 read as zero. `bus_rdata` shows the addressed register in the same cycle.
- R2: A byte access (`bus_byte`=1) takes its data from `bus_wdata[7:0]`. With `bus_addr[0]`=1 it replaces only bits 15:8, and with `bus_addr[0]`=0 it replaces only bits 7:0. This applies to the byte count, address and command registers.
- R3: The data buffer holds 8 bits and reads with bits 15:8 zero. A word write or an even byte write loads `bus_wdata[7:0]`. An odd byte write leaves it unchanged.
- R4: A command write while done is clear sets status bit 15 (illegal) and changes no command field and no go output.
- R5: A command write with done set and bit 12 set resets the controller. Command reads 0x0080, the byte count, address, data buffer, error flags and read-lines toggle clear, and `irq` drops.
- R6: A command write with bit 6 (interrupt enable) = 0 clears `irq`. A write that changes bit 6 from 0 to 1 while done or error is set raises `irq`. `irq` is never high while enable is 0.
- R7: A command write with done set and go (bit 0) set is rejected if the selected drive is offline, is busy, or is write-locked while the function (bits 3:1) is 2, 3 or 6. A rejected command sets illegal, keeps done set, produces no go pulse, and raises `irq` if the new enable is 1.
- R8: An accepted go clears done, `irq` and all status error bits, and drives `go_pulse` high for exactly one cycle after the write. During that cycle `go_fn` and `go_unit` carry the written function and unit.
- R9: A taken completion sets done, ORs `cmpl_err` into status bits 15:7, loads the byte count, address and extended-address field from the record, and raises `irq` only if enable is 1.
- R10: Each read of read lines flips bit 15 and returns the flipped value. The other bits read as zero, so the first read after reset returns 0x8000.
- R11: Status bits 6, 5, 2 and 1 show online, beginning of tape, write-locked and rewinding of the drive chosen by the command unit field. Bit 0 is the inverse of that drive's busy line. Bits 4 and 3 read as zero.
- R12: Command bit 15 (error) reads as the OR of status bits 15 through 7.
- R13: Command fields read back at fixed places: function 3:1, extended address 5:4, enable 6, done 7, unit 10:8, parity select 11, density 14:13. Go (bit 0) and init (bit 12) read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_byte | input | 1 | 1 = byte access |
| bus_addr | input | 4 | Byte address within the register block |
| bus_wdata | input | 16 | Write data (byte data in bits 7:0) |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| drv_online | input | NUM_DRIVES | Per-drive online |
| drv_bot | input | NUM_DRIVES | Per-drive at beginning of tape |
| drv_wlock | input | NUM_DRIVES | Per-drive write-locked |
| drv_rewind | input | NUM_DRIVES | Per-drive rewinding |
| drv_busy | input | NUM_DRIVES | Per-drive busy |
| go_pulse | output | 1 | One-cycle start to the transfer engine |
| go_fn | output | 3 | Function code |
| go_unit | output | 3 | Drive number |
| xfer_count | output | 16 | Byte count register |
| xfer_addr | output | 18 | Extended address and current address |
| xfer_density | output | 2 | Density field |
| xfer_parity | output | 1 | Parity select |
| cmpl_valid | input | 1 | Completion record valid |
| cmpl_ready | output | 1 | Completion can be taken (done clear) |
| cmpl_err | input | 9 | Error flags for status bits 15:7 |
| cmpl_count | input | 16 | Final byte count |
| cmpl_addr | input | 18 | Final 18-bit address |
| irq | output | 1 | Interrupt request |

## Verification
The go path is tried against four drive states: online and idle, offline, busy, and write-locked. The locked drive gets both a write function and a read function, which shows that only writes are refused. Command writes are issued with done set and with done clear, so an ignored command is told apart from an accepted one. Byte writes at odd and even addresses are checked against word writes on three registers, which separates lane merging from whole-word loading. Interrupt enable is turned on with done pending, written again while already on, and turned off, and the results separate the raise-on-enable rule from plain level tracking.

// File: rtl/tape_ctl_pkg.sv
package tape_ctl_pkg;
  localparam int REG_W    = 16;
  localparam int UNIT_FW  = 3;
  localparam int ERRF_W   = 9;
  localparam int NUM_REGS = 6;
  localparam int IDX_W    = 3;

  // command register bit positions
  localparam int CB_GO   = 0;
  localparam int CB_INIT = 12;
  // index of the illegal flag within the error-flag vector (status bit 15)
  localparam int EF_ILL  = ERRF_W - 1;

  typedef enum logic [2:0] {
    FN_UNLOAD   = 3'd0,
    FN_READ     = 3'd1,
    FN_WRITE    = 3'd2,
    FN_WMARK    = 3'd3,
    FN_SKIP_FWD = 3'd4,
    FN_SKIP_REV = 3'd5,
    FN_WGAP     = 3'd6,
    FN_REWIND   = 3'd7
  } tape_fn_e;

  typedef enum logic [IDX_W-1:0] {
    RI_STAT  = 3'd0,
    RI_CMD   = 3'd1,
    RI_COUNT = 3'd2,
    RI_ADDR  = 3'd3,
    RI_DBUF  = 3'd4,
    RI_LINES = 3'd5
  } reg_idx_e;

  typedef struct packed {
    logic [1:0]         den;
    logic               par_sel;
    logic [UNIT_FW-1:0] unit;
    logic               ie;
    logic [1:0]         ext;
    tape_fn_e           fn;
  } cmd_rw_t;

  function automatic logic [REG_W-1:0] lane_merge(input logic [REG_W-1:0] old_w,
                                                  input logic [REG_W-1:0] wd,
                                                  input logic is_byte,
                                                  input logic odd);
    if (!is_byte)  return wd;
    else if (odd)  return {wd[7:0], old_w[7:0]};
    else           return {old_w[15:8], wd[7:0]};
  endfunction

  function automatic logic fn_writes(input tape_fn_e f);
    return (f == FN_WRITE) || (f == FN_WMARK) || (f == FN_WGAP);
  endfunction

  function automatic logic [REG_W-1:0] cmd_pack(input cmd_rw_t c, input logic done,
                                                input logic err);
    return {err, c.den, 1'b0, c.par_sel, c.unit, done, c.ie, c.ext, c.fn, 1'b0};
  endfunction

  function automatic cmd_rw_t cmd_unpack(input logic [REG_W-1:0] w);
    cmd_rw_t c;
    c.den     = w[14:13];
    c.par_sel = w[11];
    c.unit    = w[10:8];
    c.ie      = w[6];
    c.ext     = w[5:4];
    c.fn      = tape_fn_e'(w[3:1]);
    return c;
  endfunction
endpackage

// File: rtl/tape_addr_dec.sv
module tape_addr_dec
  import tape_ctl_pkg::*;
(
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [IDX_W-1:0]    idx,
  output logic [NUM_REGS-1:0] wr_hit,
  output logic [NUM_REGS-1:0] rd_hit
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
    assign wr_hit[g] = bus_sel &  bus_wr & (idx == IDX_W'(g));
    assign rd_hit[g] = bus_sel & ~bus_wr & (idx == IDX_W'(g));
  end
endmodule

// File: rtl/tape_drive_sel.sv
module tape_drive_sel #(
  parameter int NUM_DRIVES = 8,
  parameter int FW         = 5,
  parameter int UW         = 3
) (
  input  logic [UW-1:0]                 unit,
  input  logic [NUM_DRIVES-1:0][FW-1:0] vec,
  output logic [FW-1:0]                 sel
);
  // a unit number with no drive behind it reads as all conditions low
  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_DRIVES; i++) begin
      if (int'(unit) == i) sel = vec[i];
    end
  end
endmodule

// File: rtl/tape_cmd_ctl.sv
module tape_cmd_ctl
  import tape_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_we,
  input  logic               cmd_byte,
  input  logic               cmd_odd,
  input  logic [REG_W-1:0]   wdata,
  input  logic               g_online,
  input  logic               g_wlock,
  input  logic               g_busy,
  input  logic               cmpl_take,
  input  logic [ERRF_W-1:0]  cmpl_err,
  input  logic [1:0]         cmpl_ext,
  output cmd_rw_t            cmd_q,
  output logic               done_q,
  output logic               irq_q,
  output logic [ERRF_W-1:0]  errf_q,
  output logic               go_q,
  output logic               init_now,
  output logic [UNIT_FW-1:0] pend_unit
);
  cmd_rw_t             n_cmd, new_f;
  logic                n_done, n_irq, n_go;
  logic [ERRF_W-1:0]   n_errf;
  logic [REG_W-1:0]    cur_w, merged;
  logic                err_any, go_bad;

  assign err_any   = |errf_q;
  assign cur_w     = cmd_pack(cmd_q, done_q, err_any);
  assign merged    = lane_merge(cur_w, wdata, cmd_byte, cmd_odd);
  assign new_f     = cmd_unpack(merged);
  assign pend_unit = new_f.unit;
  assign init_now  = cmd_we && done_q && merged[CB_INIT];
  assign go_bad    = !g_online || g_busy || (fn_writes(new_f.fn) && g_wlock);

  always_comb begin
    n_cmd  = cmd_q;
    n_done = done_q;
    n_irq  = irq_q;
    n_errf = errf_q;
    n_go   = 1'b0;
    if (cmpl_take) begin
      n_done    = 1'b1;
      n_errf    = n_errf | cmpl_err;
      n_cmd.ext = cmpl_ext;
      if (cmd_q.ie) n_irq = 1'b1;
    end
    if (cmd_we) begin
      if (!done_q) begin
        n_errf[EF_ILL] = 1'b1;
      end else if (merged[CB_INIT]) begin
        n_cmd  = '0;
        n_done = 1'b1;
        n_irq  = 1'b0;
        n_errf = '0;
      end else begin
        if (!new_f.ie)                              n_irq = 1'b0;
        else if (!cmd_q.ie && (done_q || err_any))  n_irq = 1'b1;
        n_cmd = new_f;
        if (merged[CB_GO]) begin
          if (go_bad) begin
            n_errf[EF_ILL] = 1'b1;
            n_done         = 1'b1;
            if (new_f.ie) n_irq = 1'b1;
          end else begin
            n_errf = '0;
            n_done = 1'b0;
            n_irq  = 1'b0;
            n_go   = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      done_q <= 1'b1;
      irq_q  <= 1'b0;
      errf_q <= '0;
      go_q   <= 1'b0;
    end else begin
      cmd_q  <= n_cmd;
      done_q <= n_done;
      irq_q  <= n_irq;
      errf_q <= n_errf;
      go_q   <= n_go;
    end
  end
endmodule

// File: rtl/tape_ctl_regs.sv
module tape_ctl_regs
  import tape_ctl_pkg::*;
#(
  parameter int NUM_DRIVES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic                  bus_byte,
  input  logic [3:0]            bus_addr,
  input  logic [15:0]           bus_wdata,
  output logic [15:0]           bus_rdata,
  input  logic [NUM_DRIVES-1:0] drv_online,
  input  logic [NUM_DRIVES-1:0] drv_bot,
  input  logic [NUM_DRIVES-1:0] drv_wlock,
  input  logic [NUM_DRIVES-1:0] drv_rewind,
  input  logic [NUM_DRIVES-1:0] drv_busy,
  output logic                  go_pulse,
  output logic [2:0]            go_fn,
  output logic [2:0]            go_unit,
  output logic [15:0]           xfer_count,
  output logic [17:0]           xfer_addr,
  output logic [1:0]            xfer_density,
  output logic                  xfer_parity,
  input  logic                  cmpl_valid,
  output logic                  cmpl_ready,
  input  logic [8:0]            cmpl_err,
  input  logic [15:0]           cmpl_count,
  input  logic [17:0]           cmpl_addr,
  output logic                  irq
);
  localparam int ST_FW = 5;   // online, bot, wlock, rewind, busy
  localparam int GO_FW = 3;   // online, wlock, busy

  logic [NUM_REGS-1:0]              wr_hit, rd_hit;
  logic [NUM_DRIVES-1:0][ST_FW-1:0] st_vec;
  logic [NUM_DRIVES-1:0][GO_FW-1:0] go_vec;
  logic [ST_FW-1:0]                 st_sel;
  logic [GO_FW-1:0]                 go_sel;
  cmd_rw_t                          cmd_q;
  logic                             cmd_done, cmd_ie, init_now, cmpl_take;
  logic [ERRF_W-1:0]                errf_q;
  logic [UNIT_FW-1:0]               pend_unit;
  logic [REG_W-1:0]                 count_q, addr_q, stat_w;
  logic [7:0]                       dbuf_q;
  logic                             lines_q;
  logic                             unused_hits;

  tape_addr_dec u_dec (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .idx     (bus_addr[3:1]),
    .wr_hit  (wr_hit),
    .rd_hit  (rd_hit)
  );
  assign unused_hits = ^{wr_hit[RI_STAT], wr_hit[RI_LINES], rd_hit[RI_STAT],
                         rd_hit[RI_CMD], rd_hit[RI_COUNT], rd_hit[RI_ADDR], rd_hit[RI_DBUF]};

  for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drv
    assign st_vec[g] = {drv_online[g], drv_bot[g], drv_wlock[g], drv_rewind[g], drv_busy[g]};
    assign go_vec[g] = {drv_online[g], drv_wlock[g], drv_busy[g]};
  end

  // conditions of the drive currently named in the command register
  tape_drive_sel #(.NUM_DRIVES(NUM_DRIVES), .FW(ST_FW), .UW(UNIT_FW)) u_st_sel (
    .unit (cmd_q.unit),
    .vec  (st_vec),
    .sel  (st_sel)
  );

  // conditions of the drive named by the command being written
  tape_drive_sel #(.NUM_DRIVES(NUM_DRIVES), .FW(GO_FW), .UW(UNIT_FW)) u_go_sel (
    .unit (pend_unit),
    .vec  (go_vec),
    .sel  (go_sel)
  );

  assign cmpl_ready = ~cmd_done;
  assign cmpl_take  = cmpl_valid & ~cmd_done;

  tape_cmd_ctl u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (wr_hit[RI_CMD]),
    .cmd_byte  (bus_byte),
    .cmd_odd   (bus_addr[0]),
    .wdata     (bus_wdata),
    .g_online  (go_sel[2]),
    .g_wlock   (go_sel[1]),
    .g_busy    (go_sel[0]),
    .cmpl_take (cmpl_take),
    .cmpl_err  (cmpl_err),
    .cmpl_ext  (cmpl_addr[17:16]),
    .cmd_q     (cmd_q),
    .done_q    (cmd_done),
    .irq_q     (irq),
    .errf_q    (errf_q),
    .go_q      (go_pulse),
    .init_now  (init_now),
    .pend_unit (pend_unit)
  );
  assign cmd_ie = cmd_q.ie;

  always_ff @(posedge clk) begin
    if (!rst_n || init_now) begin
      count_q <= '0;
      addr_q  <= '0;
      dbuf_q  <= '0;
      lines_q <= 1'b0;
    end else begin
      if (cmpl_take) begin
        count_q <= cmpl_count;
        addr_q  <= cmpl_addr[15:0];
      end else begin
        if (wr_hit[RI_COUNT]) count_q <= lane_merge(count_q, bus_wdata, bus_byte, bus_addr[0]);
        if (wr_hit[RI_ADDR])  addr_q  <= lane_merge(addr_q, bus_wdata, bus_byte, bus_addr[0]);
      end
      if (wr_hit[RI_DBUF] && !(bus_byte && bus_addr[0])) dbuf_q <= bus_wdata[7:0];
      if (rd_hit[RI_LINES]) lines_q <= ~lines_q;
    end
  end

  assign stat_w = {errf_q, st_sel[4], st_sel[3], 2'b00, st_sel[2], st_sel[1], ~st_sel[0]};

  always_comb begin
    case (reg_idx_e'(bus_addr[3:1]))
      RI_STAT:  bus_rdata = stat_w;
      RI_CMD:   bus_rdata = cmd_pack(cmd_q, cmd_done, |errf_q);
      RI_COUNT: bus_rdata = count_q;
      RI_ADDR:  bus_rdata = addr_q;
      RI_DBUF:  bus_rdata = {8'h00, dbuf_q};
      RI_LINES: bus_rdata = {~lines_q, 15'h0000};
      default:  bus_rdata = '0;
    endcase
  end

  assign go_fn        = cmd_q.fn;
  assign go_unit      = cmd_q.unit;
  assign xfer_count   = count_q;
  assign xfer_addr    = {cmd_q.ext, addr_q};
  assign xfer_density = cmd_q.den;
  assign xfer_parity  = cmd_q.par_sel;
endmodule

// File: rtl/tape_ctl_regs_chk.sv
module tape_ctl_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [2:0] bus_idx,
  input logic       go_pulse,
  input logic [2:0] go_fn,
  input logic [2:0] go_unit,
  input logic       irq,
  input logic       cmpl_valid,
  input logic       cmpl_ready,
  input logic       cmd_done,
  input logic       cmd_ie
);
  AST_GO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    go_pulse |=> !go_pulse);                                              // R8
  AST_GO_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    go_pulse |-> (!cmd_done && !irq));                                    // R8
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cmd_ie);                                                      // R6
  AST_CMPL_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_valid && cmpl_ready) |=> cmd_done);                             // R9
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_idx == 3'd1 && !cmd_done && !cmpl_valid)
      |=> (!go_pulse && $stable(go_fn) && $stable(go_unit)));            // R4
endmodule

bind tape_ctl_regs tape_ctl_regs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_idx    (bus_addr[3:1]),
  .go_pulse   (go_pulse),
  .go_fn      (go_fn),
  .go_unit    (go_unit),
  .irq        (irq),
  .cmpl_valid (cmpl_valid),
  .cmpl_ready (cmpl_ready),
  .cmd_done   (cmd_done),
  .cmd_ie     (cmd_ie)
);

// File: tb/sim_tape_ctl_regs.sv
`timescale 1ns/1ps
module sim_tape_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_byte = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  drv_online = '0, drv_bot = '0, drv_wlock = '0, drv_rewind = '0, drv_busy = '0;
  logic        go_pulse;
  logic [2:0]  go_fn, go_unit;
  logic [15:0] xfer_count;
  logic [17:0] xfer_addr;
  logic [1:0]  xfer_density;
  logic        xfer_parity;
  logic        cmpl_valid = 1'b0;
  logic        cmpl_ready;
  logic [8:0]  cmpl_err = '0;
  logic [15:0] cmpl_count = '0;
  logic [17:0] cmpl_addr = '0;
  logic        irq;

  int n_run = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tape_ctl_regs u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    drv_online = '0; drv_bot = '0; drv_wlock = '0; drv_rewind = '0; drv_busy = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic is_byte);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_byte = is_byte; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_byte = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    chk(tag, {16'h0, d}, {16'h0, exp});
  endtask

  task automatic complete(input logic [8:0] e, input logic [15:0] c, input logic [17:0] a);
    @(negedge clk);
    cmpl_valid = 1'b1; cmpl_err = e; cmpl_count = c; cmpl_addr = a;
    @(negedge clk);
    cmpl_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    rd_chk("R11 status after reset", 4'd0, 16'h0001);
    rd_chk("R13 command after reset", 4'd2, 16'h0080);
    rd_chk("R1 count after reset", 4'd4, 16'h0000);
    chk("R6 irq after reset", {31'h0, irq}, 32'h0);
    chk("R9 cmpl_ready low while done", {31'h0, cmpl_ready}, 32'h0);
  endtask

  task automatic t_map_lanes();
    do_reset();
    wr(4'd4, 16'h1234, 1'b0);
    rd_chk("R1 count word write", 4'd4, 16'h1234);
    wr(4'd5, 16'h00AB, 1'b1);
    rd_chk("R2 count odd byte", 4'd4, 16'hAB34);
    wr(4'd4, 16'hFFCD, 1'b1);
    rd_chk("R2 count even byte", 4'd4, 16'hABCD);
    wr(4'd6, 16'h0FF0, 1'b0);
    wr(4'd7, 16'h0055, 1'b1);
    rd_chk("R2 address odd byte", 4'd6, 16'h55F0);
    chk("R2 xfer_addr follows", {14'h0, xfer_addr}, {14'h0, 18'h055F0});
    rd_chk("R1 index 6 reads zero", 4'd12, 16'h0000);
    rd_chk("R1 index 7 reads zero", 4'd14, 16'h0000);
    wr(4'd0, 16'hFFFF, 1'b0);
    rd_chk("R1 status write ignored", 4'd0, 16'h0001);
  endtask

  task automatic t_dbuf();
    do_reset();
    wr(4'd8, 16'h1234, 1'b0);
    rd_chk("R3 dbuf word write keeps 8 bits", 4'd8, 16'h0034);
    wr(4'd9, 16'h0077, 1'b1);
    rd_chk("R3 dbuf odd byte ignored", 4'd8, 16'h0034);
    wr(4'd8, 16'h0099, 1'b1);
    rd_chk("R3 dbuf even byte", 4'd8, 16'h0099);
  endtask

  task automatic t_lines();
    do_reset();
    rd_chk("R10 lines first read", 4'd10, 16'h8000);
    rd_chk("R10 lines second read", 4'd10, 16'h0000);
    rd_chk("R10 lines third read", 4'd10, 16'h8000);
  endtask

  task automatic t_layout();
    do_reset();
    drv_online[3] = 1'b1; drv_bot[3] = 1'b1; drv_wlock[3] = 1'b1;
    wr(4'd2, 16'h4B12, 1'b0);
    rd_chk("R13 command fields read back", 4'd2, 16'h4B92);
    chk("R13 density out", {30'h0, xfer_density}, 32'd2);
    chk("R13 parity out", {31'h0, xfer_parity}, 32'd1);
    chk("R13 ext address out", {14'h0, xfer_addr}, {14'h0, 18'h10000});
    chk("R8 no go without go bit", {31'h0, go_pulse}, 32'h0);
    rd_chk("R11 status of drive 3", 4'd0, 16'h0065);
    wr(4'd3, 16'h0001, 1'b1);
    rd_chk("R2 command odd byte", 4'd2, 16'h0192);
    rd_chk("R11 status of drive 1 idle", 4'd0, 16'h0001);
    drv_busy[1] = 1'b1; drv_rewind[1] = 1'b1;
    rd_chk("R11 busy clears ready, rewind shown", 4'd0, 16'h0002);
  endtask

  task automatic t_ie();
    do_reset();
    wr(4'd2, 16'h0040, 1'b0);
    chk("R6 enable with done pending raises irq", {31'h0, irq}, 32'h1);
    wr(4'd2, 16'h0040, 1'b0);
    chk("R6 enable rewritten keeps irq", {31'h0, irq}, 32'h1);
    wr(4'd2, 16'h0000, 1'b0);
    chk("R6 enable off clears irq", {31'h0, irq}, 32'h0);
    wr(4'd2, 16'h0040, 1'b0);
    chk("R6 enable again raises irq", {31'h0, irq}, 32'h1);
  endtask

  task automatic t_go_ok();
    do_reset();
    drv_online[0] = 1'b1;
    wr(4'd2, 16'h0043, 1'b0);
    chk("R8 go pulse", {31'h0, go_pulse}, 32'h1);
    chk("R8 go function", {29'h0, go_fn}, 32'd1);
    chk("R8 go unit", {29'h0, go_unit}, 32'd0);
    chk("R8 irq cleared by go", {31'h0, irq}, 32'h0);
    chk("R9 cmpl_ready while running", {31'h0, cmpl_ready}, 32'h1);
    @(negedge clk);
    chk("R8 go lasts one cycle", {31'h0, go_pulse}, 32'h0);
    rd_chk("R8 done clear while running", 4'd2, 16'h0042);
    wr(4'd2, 16'h0000, 1'b0);
    chk("R4 busy write gives no go", {31'h0, go_pulse}, 32'h0);
    rd_chk("R4 illegal set", 4'd0, 16'h8041);
    rd_chk("R12 error bit follows illegal, fields kept", 4'd2, 16'h8042);
    complete(9'h080, 16'h0010, 18'h12000);
    chk("R9 irq on completion with enable", {31'h0, irq}, 32'h1);
    chk("R9 cmpl_ready drops", {31'h0, cmpl_ready}, 32'h0);
    rd_chk("R9 flags ORed into status", 4'd0, 16'hC041);
    rd_chk("R9 count loaded", 4'd4, 16'h0010);
    rd_chk("R9 address loaded", 4'd6, 16'h2000);
    rd_chk("R9 command after completion", 4'd2, 16'h80D2);
    complete(9'h1FF, 16'hFFFF, 18'h3FFFF);
    rd_chk("R9 completion ignored when not ready", 4'd4, 16'h0010);
    wr(4'd2, 16'h0043, 1'b0);
    rd_chk("R8 accepted go clears error flags", 4'd0, 16'h0041);
  endtask

  task automatic t_go_bad();
    do_reset();
    wr(4'd2, 16'h0143, 1'b0);
    chk("R7 offline drive no go", {31'h0, go_pulse}, 32'h0);
    chk("R7 rejected go raises irq", {31'h0, irq}, 32'h1);
    rd_chk("R7 rejected command readback", 4'd2, 16'h81C2);
    rd_chk("R7 offline illegal status", 4'd0, 16'h8001);
    do_reset();
    drv_online[2] = 1'b1; drv_wlock[2] = 1'b1;
    wr(4'd2, 16'h0205, 1'b0);
    chk("R7 write to locked drive no go", {31'h0, go_pulse}, 32'h0);
    chk("R7 no irq without enable", {31'h0, irq}, 32'h0);
    rd_chk("R7 locked illegal status", 4'd0, 16'h8045);
    wr(4'd2, 16'h0203, 1'b0);
    chk("R7 read on locked drive accepted", {31'h0, go_pulse}, 32'h1);
    do_reset();
    drv_online[0] = 1'b1; drv_busy[0] = 1'b1;
    wr(4'd2, 16'h0003, 1'b0);
    chk("R7 busy drive no go", {31'h0, go_pulse}, 32'h0);
    rd_chk("R7 busy illegal status", 4'd0, 16'h8040);
  endtask

  task automatic t_init();
    logic [15:0] d;
    do_reset();
    wr(4'd4, 16'h1111, 1'b0);
    wr(4'd6, 16'h2222, 1'b0);
    wr(4'd8, 16'h0033, 1'b0);
    rd(4'd10, d);
    wr(4'd2, 16'h0040, 1'b0);
    wr(4'd2, 16'h1000, 1'b0);
    chk("R5 init drops irq", {31'h0, irq}, 32'h0);
    rd_chk("R5 command after init", 4'd2, 16'h0080);
    rd_chk("R5 count cleared", 4'd4, 16'h0000);
    rd_chk("R5 address cleared", 4'd6, 16'h0000);
    rd_chk("R5 dbuf cleared", 4'd8, 16'h0000);
    rd_chk("R5 lines toggle cleared", 4'd10, 16'h8000);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_map_lanes();
        t_dbuf();
        t_lines();
        t_layout();
        t_ie();
        t_go_ok();
        t_go_bad();
        t_init();
      end
      begin
        #(8 * 100000);
        n_run++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule